// File: doc/BRIEF.md
# Chained Vector Execution Pipeline

A single-lane vector execution block with eight registers of 64 elements, 64 bits each. It holds two fully pipelined functional units, an integer adder with a start-up latency of 6 cycles and an integer multiplier with a start-up latency of 7 cycles. Each unit runs one element-wise instruction at a time. An instruction covers as many elements as the vector length register holds at the moment of issue. Every result keeps the low 64 bits of the two's-complement sum or product, and element n of the result depends only on element n of the operands.

The two units share the register file and chain through it. Each register carries a count of the elements its current producer has already written. A consumer on the other unit can therefore start on element i in the cycle after that element lands, without waiting for the whole vector. Instructions enter through a single issue port that accepts or refuses them in the same cycle. A host port writes and reads single elements, so operands can be loaded and results checked without a memory path.

Top module: `vchain_top`

## Requirements
- R1: A host write to register `host_reg`, element `host_idx`, stores `host_wdata`. The combinational read port `host_rdata` returns the element chosen by `host_rreg`/`host_ridx`.
- R2: A write to the vector length register stores `vl_wdata` if it is 64 or less and stores 64 otherwise. `vl_value` shows the stored value from the next cycle on.
- R3: The opcode `iss_op` selects the operation. 2'b00 adds two vectors, 2'b01 adds the scalar to every element, 2'b10 multiplies two vectors element by element, and 2'b11 multiplies every element by the scalar. Results wrap to 64 bits.
- R4: Both units write one element per clock after their start-up latency. If an instruction is issued at clock edge E with vector length n, its element i is written at edge E+L+i, where L is 6 for the adder (opcodes 2'b0x) and 7 for the multiplier (2'b1x). The unit's bit in `unit_done` pulses for one cycle after the last write, and its bit in `unit_busy` clears at that edge. Bit 0 belongs to the adder and bit 1 to the multiplier.
- R5: An instruction that reads a register still being produced by the other unit reads element i in the cycle after that element is written. It then writes element i L cycles later. With VL=64, a vector-scalar multiply issued at E and a dependent vector add issued at E+1 finish at edges E+70 and E+76.
- R6: `iss_accept` is low, and the issue has no effect, in two cases: the target unit is busy, or the destination equals the destination or a source register of the instruction active on the other unit.
- R7: An accepted instruction issued with VL=0 writes no element. It leaves the unit idle and pulses that unit's `unit_done` in the next cycle.
- R8: Elements at indices at or above the VL captured at issue keep their old contents. An instruction may name its own destination as a source.
- R9: The adder and the multiplier run independent instructions at the same time.
- R10: After reset, `unit_busy` and `unit_done` are zero and `vl_value` is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vl_we | input | 1 | Write strobe for the vector length register |
| vl_wdata | input | 8 | Requested vector length (clamped to 64) |
| vl_value | output | 7 | Current vector length |
| iss_valid | input | 1 | Instruction offered this cycle |
| iss_op | input | 2 | Opcode; bit 1 selects the multiplier, bit 0 selects the scalar operand |
| iss_vd | input | 3 | Destination register |
| iss_vs1 | input | 3 | First source register |
| iss_vs2 | input | 3 | Second source register (ignored for scalar forms) |
| iss_scalar | input | 64 | Scalar operand |
| iss_accept | output | 1 | Instruction taken at the coming edge |
| host_we | input | 1 | Host element write strobe |
| host_reg | input | 3 | Host write register |
| host_idx | input | 6 | Host write element |
| host_wdata | input | 64 | Host write data |
| host_rreg | input | 3 | Host read register |
| host_ridx | input | 6 | Host read element |
| host_rdata | output | 64 | Host read data |
| unit_busy | output | 2 | Busy per unit (bit 0 adder, bit 1 multiplier) |
| unit_done | output | 2 | One-cycle completion pulse per unit |

## Verification
The assertions assume that the host does not write an element while a unit writes the same element. They also assume that an idle unit is never handed an instruction that breaks the refusal rules. The bench does all host writes with both units idle and offers instructions only through the issue port. It does offer forbidden ones there, to exercise the refusal path. A behavioural model in the bench tracks per-register written counts and a write time for each element, and every clock it compares acceptance, busy, done, the vector length and the host read data against the ports.

// File: rtl/vchain_pkg.sv
// Package: shared opcode encoding for the chained vector pipeline.
// Assumes bit 1 of an opcode picks the multiplier and bit 0 picks the scalar operand.
package vchain_pkg;

    typedef enum logic [1:0] {
        OP_ADD_VV = 2'b00,
        OP_ADD_VS = 2'b01,
        OP_MUL_VV = 2'b10,
        OP_MUL_VS = 2'b11
    } vop_e;

    localparam int NUM_UNITS = 2;

endpackage

// File: rtl/vchain_vrf.sv
// Vector register file: NREG registers of VLMAX elements, EW bits each.
// Reads are combinational. Writes take effect at the clock edge, and a
// higher-numbered write port wins a clash (callers are assumed to avoid clashes).
// The contents are not reset.
module vchain_vrf #(
    parameter int EW    = 64,
    parameter int NREG  = 8,
    parameter int VLMAX = 64,
    parameter int NWR   = 3,
    parameter int NRD   = 5,
    localparam int RW   = $clog2(NREG),
    localparam int IW   = $clog2(VLMAX)
) (
    input  logic                     clk,
    input  logic [NWR-1:0]           we,
    input  logic [NWR-1:0][RW-1:0]   wreg,
    input  logic [NWR-1:0][IW-1:0]   widx,
    input  logic [NWR-1:0][EW-1:0]   wdata,
    input  logic [NRD-1:0][RW-1:0]   rreg,
    input  logic [NRD-1:0][IW-1:0]   ridx,
    output logic [NRD-1:0][EW-1:0]   rdata
);

    logic [EW-1:0] mem [NREG][VLMAX];

    // Element storage update from every write port.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NWR; p++) begin
            if (we[p]) begin
                mem[wreg[p]][widx[p]] <= wdata[p];
            end
        end
    end

    // Combinational read ports.
    genvar g;
    generate
        for (g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = mem[rreg[g]][ridx[g]];
        end
    endgenerate

endmodule

// File: rtl/vchain_unit.sv
// One pipelined vector functional unit (adder or multiplier).
// It accepts one instruction while idle and reads one element per cycle when
// the chain-ready inputs allow. The result reaches the register file LAT
// cycles after the issue edge. Assumes LAT >= 2 and in-order element reads.
module vchain_unit #(
    parameter int EW     = 64,
    parameter int NREG   = 8,
    parameter int VLMAX  = 64,
    parameter int LAT    = 6,
    parameter bit IS_MUL = 1'b0,
    localparam int RW    = $clog2(NREG),
    localparam int CW    = $clog2(VLMAX + 1),
    localparam int IW    = $clog2(VLMAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] st_vd,
    input  logic [RW-1:0] st_vs1,
    input  logic [RW-1:0] st_vs2,
    input  logic          st_use_scl,
    input  logic [EW-1:0] st_scalar,
    input  logic [CW-1:0] st_vl,
    input  logic          a_ok,
    input  logic          b_ok,
    input  logic [EW-1:0] rd_a,
    input  logic [EW-1:0] rd_b,
    output logic [CW-1:0] rd_pos,
    output logic [RW-1:0] cur_vd,
    output logic [RW-1:0] cur_vs1,
    output logic [RW-1:0] cur_vs2,
    output logic          cur_use_scl,
    output logic          busy,
    output logic          done,
    output logic          wb_en,
    output logic          wb_last,
    output logic [RW-1:0] wb_reg,
    output logic [IW-1:0] wb_idx,
    output logic [EW-1:0] wb_data
);

    localparam int DEPTH = LAT - 1;

    logic          busy_q, done_q, use_q;
    logic [RW-1:0] vd_q, vs1_q, vs2_q;
    logic [EW-1:0] scl_q;
    logic [CW-1:0] vl_q, rd_q, wr_q;
    logic          fire;
    logic [EW-1:0] opb, res;
    logic [DEPTH-1:0] pv;
    logic [IW-1:0] pidx [DEPTH];
    logic [EW-1:0] pdat [DEPTH];

    // Read the next element when active, in range and chain-ready.
    assign fire = busy_q && (rd_q < vl_q) && a_ok && (use_q || b_ok);
    assign opb  = use_q ? scl_q : rd_b;

    // Operation variant chosen by parameter.
    generate
        if (IS_MUL) begin : g_mul
            assign res = rd_a * opb;
        end else begin : g_add
            assign res = rd_a + opb;
        end
    endgenerate

    // Sequencer: capture the instruction, advance the read and write counts, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            use_q  <= 1'b0;
            vd_q   <= '0;
            vs1_q  <= '0;
            vs2_q  <= '0;
            scl_q  <= '0;
            vl_q   <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                if (st_vl == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    vd_q   <= st_vd;
                    vs1_q  <= st_vs1;
                    vs2_q  <= st_vs2;
                    use_q  <= st_use_scl;
                    scl_q  <= st_scalar;
                    vl_q   <= st_vl;
                    rd_q   <= '0;
                    wr_q   <= '0;
                end
            end else if (busy_q) begin
                if (fire) begin
                    rd_q <= rd_q + CW'(1);
                end
                if (wb_en) begin
                    wr_q <= wr_q + CW'(1);
                    if (wb_last) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    // Pipeline valid bits (reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= '0;
        end else begin
            pv[0] <= fire;
            for (int k = 1; k < DEPTH; k++) begin
                pv[k] <= pv[k-1];
            end
        end
    end

    // Pipeline payload: element index and result.
    always_ff @(posedge clk) begin
        pidx[0] <= rd_q[IW-1:0];
        pdat[0] <= res;
        for (int k = 1; k < DEPTH; k++) begin
            pidx[k] <= pidx[k-1];
            pdat[k] <= pdat[k-1];
        end
    end

    assign wb_en       = pv[DEPTH-1];
    assign wb_last     = pv[DEPTH-1] && ((wr_q + CW'(1)) == vl_q);
    assign wb_reg      = vd_q;
    assign wb_idx      = pidx[DEPTH-1];
    assign wb_data     = pdat[DEPTH-1];
    assign rd_pos      = rd_q;
    assign cur_vd      = vd_q;
    assign cur_vs1     = vs1_q;
    assign cur_vs2     = vs2_q;
    assign cur_use_scl = use_q;
    assign busy        = busy_q;
    assign done        = done_q;

    // R6: the issue logic only starts an idle unit.
    p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

    // R7: a zero-length instruction completes at once and leaves the unit idle.
    p_vl0_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_vl == '0) |=> (done_q && !busy_q));

    // R8: no write at or above the captured vector length.
    p_wb_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (busy_q && (CW'(wb_idx) < vl_q)));

    // R4: elements are written in ascending order.
    p_wb_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (CW'(wb_idx) == wr_q));

    // R4: the completion pulse never overlaps activity.
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

endmodule

// File: rtl/vchain_top.sv
// Chained vector execution block: vector length register, issue and hazard
// checks, per-register written-element counts for chaining, register file and
// two pipelined units (unit 0 adds, unit 1 multiplies).
// Assumes host element writes happen only while both units are idle.
module vchain_top
    import vchain_pkg::*;
#(
    parameter int EW      = 64,
    parameter int NREG    = 8,
    parameter int VLMAX   = 64,
    parameter int VLIN_W  = 8,
    parameter int ADD_LAT = 6,
    parameter int MUL_LAT = 7,
    localparam int RW     = $clog2(NREG),
    localparam int CW     = $clog2(VLMAX + 1),
    localparam int IW     = $clog2(VLMAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vl_we,
    input  logic [VLIN_W-1:0] vl_wdata,
    output logic [CW-1:0]     vl_value,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [RW-1:0]     iss_vd,
    input  logic [RW-1:0]     iss_vs1,
    input  logic [RW-1:0]     iss_vs2,
    input  logic [EW-1:0]     iss_scalar,
    output logic              iss_accept,
    input  logic              host_we,
    input  logic [RW-1:0]     host_reg,
    input  logic [IW-1:0]     host_idx,
    input  logic [EW-1:0]     host_wdata,
    input  logic [RW-1:0]     host_rreg,
    input  logic [IW-1:0]     host_ridx,
    output logic [EW-1:0]     host_rdata,
    output logic [1:0]        unit_busy,
    output logic [1:0]        unit_done
);

    localparam int NU = NUM_UNITS;

    logic [CW-1:0] vl_q;
    logic [CW-1:0] avail [NREG];
    logic [CW-1:0] avail_nxt [NREG];

    logic [NU-1:0]         start, busy, done, wb_en, wb_last, use_scl, a_ok, b_ok;
    logic [NU-1:0][RW-1:0] cur_vd, cur_vs1, cur_vs2, wb_reg;
    logic [NU-1:0][IW-1:0] wb_idx;
    logic [NU-1:0][EW-1:0] wb_data, rd_a, rd_b;
    logic [NU-1:0][CW-1:0] rd_pos;

    logic [2*NU:0][RW-1:0] rf_rreg;
    logic [2*NU:0][IW-1:0] rf_ridx;
    logic [2*NU:0][EW-1:0] rf_rdata;

    logic tgt, oth, clash;
    vop_e op;

    // Vector length register with clamp to the register length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= CW'(VLMAX);
        end else if (vl_we) begin
            vl_q <= (vl_wdata > VLIN_W'(VLMAX)) ? CW'(VLMAX) : vl_wdata[CW-1:0];
        end
    end
    assign vl_value = vl_q;

    // Issue decision: target unit idle and no register overlap with the other unit.
    assign op    = vop_e'(iss_op);
    assign tgt   = op[1];
    assign oth   = ~op[1];
    assign clash = busy[oth] && ((iss_vd == cur_vd[oth]) || (iss_vd == cur_vs1[oth]) ||
                                 (!use_scl[oth] && (iss_vd == cur_vs2[oth])));
    assign iss_accept = iss_valid && !busy[tgt] && !clash;

    // Written-element count per register: cleared at issue, bumped per write, full when done.
    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            avail_nxt[r] = avail[r];
        end
        for (int u = 0; u < NU; u++) begin
            if (wb_en[u]) begin
                avail_nxt[wb_reg[u]] = avail_nxt[wb_reg[u]] + CW'(1);
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (wb_last[u]) begin
                avail_nxt[cur_vd[u]] = CW'(VLMAX);
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (start[u] && vl_q != '0) begin
                avail_nxt[iss_vd] = '0;
            end
        end
    end

    // Written-element count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                avail[r] <= CW'(VLMAX);
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                avail[r] <= avail_nxt[r];
            end
        end
    end

    // Functional units, their read ports and chain-ready checks.
    genvar u;
    generate
        for (u = 0; u < NU; u++) begin : g_unit
            assign start[u]         = iss_accept && (tgt == 1'(u));
            assign a_ok[u]          = (cur_vs1[u] == cur_vd[u]) || (avail[cur_vs1[u]] > rd_pos[u]);
            assign b_ok[u]          = (cur_vs2[u] == cur_vd[u]) || (avail[cur_vs2[u]] > rd_pos[u]);
            assign rf_rreg[2*u]     = cur_vs1[u];
            assign rf_rreg[2*u+1]   = cur_vs2[u];
            assign rf_ridx[2*u]     = rd_pos[u][IW-1:0];
            assign rf_ridx[2*u+1]   = rd_pos[u][IW-1:0];
            assign rd_a[u]          = rf_rdata[2*u];
            assign rd_b[u]          = rf_rdata[2*u+1];

            vchain_unit #(
                .EW    (EW),
                .NREG  (NREG),
                .VLMAX (VLMAX),
                .LAT   ((u == 1) ? MUL_LAT : ADD_LAT),
                .IS_MUL(u == 1)
            ) u_fu (
                .clk        (clk),
                .rst_n      (rst_n),
                .start      (start[u]),
                .st_vd      (iss_vd),
                .st_vs1     (iss_vs1),
                .st_vs2     (iss_vs2),
                .st_use_scl (iss_op[0]),
                .st_scalar  (iss_scalar),
                .st_vl      (vl_q),
                .a_ok       (a_ok[u]),
                .b_ok       (b_ok[u]),
                .rd_a       (rd_a[u]),
                .rd_b       (rd_b[u]),
                .rd_pos     (rd_pos[u]),
                .cur_vd     (cur_vd[u]),
                .cur_vs1    (cur_vs1[u]),
                .cur_vs2    (cur_vs2[u]),
                .cur_use_scl(use_scl[u]),
                .busy       (busy[u]),
                .done       (done[u]),
                .wb_en      (wb_en[u]),
                .wb_last    (wb_last[u]),
                .wb_reg     (wb_reg[u]),
                .wb_idx     (wb_idx[u]),
                .wb_data    (wb_data[u])
            );
        end
    endgenerate

    assign rf_rreg[2*NU] = host_rreg;
    assign rf_ridx[2*NU] = host_ridx;
    assign host_rdata    = rf_rdata[2*NU];

    vchain_vrf #(
        .EW   (EW),
        .NREG (NREG),
        .VLMAX(VLMAX),
        .NWR  (NU + 1),
        .NRD  (2*NU + 1)
    ) u_vrf (
        .clk  (clk),
        .we   ({wb_en[1], wb_en[0], host_we}),
        .wreg ({wb_reg[1], wb_reg[0], host_reg}),
        .widx ({wb_idx[1], wb_idx[0], host_idx}),
        .wdata({wb_data[1], wb_data[0], host_wdata}),
        .rreg (rf_rreg),
        .ridx (rf_ridx),
        .rdata(rf_rdata)
    );

    assign unit_busy = busy;
    assign unit_done = done;

    // R2: the stored vector length never exceeds the register length.
    p_vl_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vl_q <= CW'(VLMAX));

    // R6: the two units never write the same register in one cycle.
    p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en[0] && wb_en[1]) |-> (wb_reg[0] != wb_reg[1]));

    // R5: a unit that is still working never lets its destination count reach full.
    p_chain_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && !wb_last[0]) |=> (!busy[0] || avail[cur_vd[0]] < CW'(VLMAX)));

    // R5: written-element counts stay within the register length.
    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_avail_chk
            p_avail_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
                avail[r] <= CW'(VLMAX));
        end
    endgenerate

endmodule

// File: tb/vchain_top_tb.sv
// Bench for vchain_top: a behavioural model (counts and write times per element)
// compared on every clock, plus directed checks tied to each requirement.
module vchain_top_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vl_we = 1'b0;
    logic [7:0]  vl_wdata = '0;
    logic [6:0]  vl_value;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = '0;
    logic [2:0]  iss_vd = '0, iss_vs1 = '0, iss_vs2 = '0;
    logic [63:0] iss_scalar = '0;
    logic        iss_accept;
    logic        host_we = 1'b0;
    logic [2:0]  host_reg = '0, host_rreg = '0;
    logic [5:0]  host_idx = '0, host_ridx = '0;
    logic [63:0] host_wdata = '0, host_rdata;
    logic [1:0]  unit_busy, unit_done;

    int checks = 0;
    int errors = 0;

    vchain_top u_dut (
        .clk(clk), .rst_n(rst_n), .vl_we(vl_we), .vl_wdata(vl_wdata), .vl_value(vl_value),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vd(iss_vd), .iss_vs1(iss_vs1),
        .iss_vs2(iss_vs2), .iss_scalar(iss_scalar), .iss_accept(iss_accept),
        .host_we(host_we), .host_reg(host_reg), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_rreg(host_rreg), .host_ridx(host_ridx), .host_rdata(host_rdata),
        .unit_busy(unit_busy), .unit_done(unit_done)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural model state.
    logic [63:0] rm [8][64];
    bit          rk [8][64];
    int          ravail [8];
    int          rvl = 64;
    int          cyc = 0;
    int          act [2], vd [2], s1 [2], s2 [2], us [2], uvl [2], rdp [2], wrc [2], rdone [2];
    logic [63:0] scl [2];
    int          wtime [2][64];
    logic [63:0] wval [2][64];
    logic [63:0] host_seen;
    logic        acc_seen;

    function automatic logic [63:0] gen(int r, int i);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(r + 1)) ^ (64'(i) * 64'h0001_0003_0007_000F)
               ^ {32'(i), 32'hFFFF_FFF0};
    endfunction

    function automatic int lat(int u);
        return (u == 1) ? 7 : 6;
    endfunction

    function automatic bit m_ok(int s, int u);
        return (s == vd[u]) || (ravail[s] > rdp[u]);
    endfunction

    function automatic bit m_accept();
        int t, o;
        t = int'(iss_op[1]);
        o = 1 - t;
        if (!iss_valid || act[t] != 0) return 1'b0;
        if (act[o] != 0 && (int'(iss_vd) == vd[o] || int'(iss_vd) == s1[o] ||
                            (us[o] == 0 && int'(iss_vd) == s2[o]))) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act_v, logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act_v, exp_v, cyc);
        end
    endtask

    // Advance the model across one clock edge using the inputs held at that edge.
    task automatic model_step();
        bit          f [2];
        int          fi [2];
        logic [63:0] fv [2];
        bit          acc;
        int          t;
        for (int u = 0; u < 2; u++) begin
            f[u] = (act[u] != 0) && rdp[u] < uvl[u] && m_ok(s1[u], u) && (us[u] != 0 || m_ok(s2[u], u));
            fi[u] = rdp[u];
            if (f[u]) begin
                logic [63:0] a, b;
                a = rm[s1[u]][rdp[u]];
                b = (us[u] != 0) ? scl[u] : rm[s2[u]][rdp[u]];
                fv[u] = (u == 1) ? a * b : a + b;
            end else begin
                fv[u] = '0;
            end
        end
        acc = m_accept();
        for (int u = 0; u < 2; u++) begin
            rdone[u] = 0;
            for (int i = 0; i < 64; i++) begin
                if (act[u] != 0 && wtime[u][i] == cyc) begin
                    rm[vd[u]][i] = wval[u][i];
                    rk[vd[u]][i] = 1'b1;
                    ravail[vd[u]]++;
                    wrc[u]++;
                    if (wrc[u] == uvl[u]) begin
                        act[u] = 0;
                        rdone[u] = 1;
                        ravail[vd[u]] = 64;
                    end
                end
            end
        end
        for (int u = 0; u < 2; u++) begin
            if (f[u]) begin
                wtime[u][fi[u]] = cyc + lat(u) - 1;
                wval[u][fi[u]] = fv[u];
                rdp[u]++;
            end
        end
        if (host_we) begin
            rm[host_reg][host_idx] = host_wdata;
            rk[host_reg][host_idx] = 1'b1;
        end
        if (acc) begin
            t = int'(iss_op[1]);
            if (rvl == 0) begin
                rdone[t] = 1;
            end else begin
                act[t] = 1; vd[t] = int'(iss_vd); s1[t] = int'(iss_vs1); s2[t] = int'(iss_vs2);
                us[t] = int'(iss_op[0]); scl[t] = iss_scalar; uvl[t] = rvl; rdp[t] = 0; wrc[t] = 0;
                for (int i = 0; i < 64; i++) wtime[t][i] = -1;
                ravail[int'(iss_vd)] = 0;
            end
        end
        if (vl_we) rvl = (int'(vl_wdata) > 64) ? 64 : int'(vl_wdata);
        cyc++;
    endtask

    // One clock: mid-cycle combinational compares, edge, model update, registered compares.
    task automatic tick();
        #(CLK_P/2);
        acc_seen  = iss_accept;
        host_seen = host_rdata;
        chk(iss_accept == m_accept(), "R6 accept vs model", 64'(iss_accept), 64'(m_accept()));
        if (rk[host_rreg][host_ridx])
            chk(host_rdata == rm[host_rreg][host_ridx], "R1 host read vs model",
                host_rdata, rm[host_rreg][host_ridx]);
        @(posedge clk);
        #1;
        model_step();
        chk(unit_busy == {1'(act[1]), 1'(act[0])}, "R4 busy vs model",
            64'(unit_busy), 64'({1'(act[1]), 1'(act[0])}));
        chk(unit_done == {1'(rdone[1]), 1'(rdone[0])}, "R4 done vs model",
            64'(unit_done), 64'({1'(rdone[1]), 1'(rdone[0])}));
        chk(int'(vl_value) == rvl, "R2 vl vs model", 64'(vl_value), 64'(rvl));
    endtask

    task automatic issue(logic [1:0] op, int d, int a, int b, logic [63:0] s);
        iss_valid = 1'b1; iss_op = op; iss_vd = 3'(d); iss_vs1 = 3'(a); iss_vs2 = 3'(b);
        iss_scalar = s;
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic set_vl(int v);
        vl_we = 1'b1; vl_wdata = 8'(v);
        tick();
        vl_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 400 && unit_busy != 2'b00; n++) tick();
    endtask

    task automatic readback(int r, int i, logic [63:0] exp_v, string tag);
        host_rreg = 3'(r); host_ridx = 6'(i);
        tick();
        chk(host_seen == exp_v, tag, host_seen, exp_v);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] sa, sb;
        int          n, ta, tm;
        for (int u = 0; u < 2; u++) begin
            act[u] = 0; vd[u] = 0; s1[u] = 0; s2[u] = 0; us[u] = 0; uvl[u] = 0;
            rdp[u] = 0; wrc[u] = 0; rdone[u] = 0; scl[u] = '0;
            for (int i = 0; i < 64; i++) begin wtime[u][i] = -1; wval[u][i] = '0; end
        end
        for (int r = 0; r < 8; r++) begin
            ravail[r] = 64;
            for (int i = 0; i < 64; i++) begin rk[r][i] = 1'b0; rm[r][i] = '0; end
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state.
        chk(unit_busy == 2'b00, "R10 busy after reset", 64'(unit_busy), 64'd0);
        chk(unit_done == 2'b00, "R10 done after reset", 64'(unit_done), 64'd0);
        chk(vl_value == 7'd64, "R10 vl after reset", 64'(vl_value), 64'd64);

        // R1: fill every register through the host port.
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 64; i++) begin
                host_we = 1'b1; host_reg = 3'(r); host_idx = 6'(i); host_wdata = gen(r, i);
                tick();
            end
        end
        host_we = 1'b0;
        readback(4, 17, gen(4, 17), "R1 host write then read");

        // R2: clamp and plain write of the vector length.
        set_vl(200);
        chk(vl_value == 7'd64, "R2 clamp of 200", 64'(vl_value), 64'd64);
        set_vl(37);
        chk(vl_value == 7'd37, "R2 store of 37", 64'(vl_value), 64'd37);

        // R4: start-up latency with VL=1 for both units.
        set_vl(1);
        issue(2'b00, 5, 0, 1, '0);
        n = 0;
        while (unit_done[0] == 1'b0 && n < 50) begin tick(); n++; end
        chk(n == 6, "R4 adder latency", 64'(n), 64'd6);
        issue(2'b10, 6, 0, 1, '0);
        n = 0;
        while (unit_done[1] == 1'b0 && n < 50) begin tick(); n++; end
        chk(n == 7, "R4 multiplier latency", 64'(n), 64'd7);
        readback(5, 0, gen(0, 0) + gen(1, 0), "R3 add vv element 0");
        readback(6, 0, gen(0, 0) * gen(1, 0), "R3 mul vv element 0");
        readback(5, 1, gen(5, 1), "R8 element beyond VL=1 kept");

        // R5: chained multiply then add with VL=64.
        set_vl(64);
        sa = 64'hFFFF_FFFF_FFFF_FFFD;
        issue(2'b11, 2, 1, 0, sa);
        issue(2'b00, 4, 2, 3, '0);
        n = 1; ta = -1; tm = -1;
        while (ta < 0 && n < 400) begin
            tick(); n++;
            if (unit_done[1]) tm = n;
            if (unit_done[0]) ta = n;
        end
        chk(tm == 70, "R5 multiply finish edge", 64'(tm), 64'd70);
        chk(ta == 76, "R5 chained add finish edge", 64'(ta), 64'd76);
        for (int i = 0; i < 64; i += 9)
            readback(4, i, gen(1, i) * sa + gen(3, i), "R3 mul vs then add vv");
        readback(4, 63, gen(1, 63) * sa + gen(3, 63), "R3 last element");

        // R6 and R9: refusals, then both units active together.
        issue(2'b10, 6, 0, 3, '0);
        chk(acc_seen == 1'b1, "R6 multiply accepted", 64'(acc_seen), 64'd1);
        issue(2'b11, 7, 1, 0, sa);
        chk(acc_seen == 1'b0, "R6 busy unit refuses", 64'(acc_seen), 64'd0);
        issue(2'b00, 6, 1, 2, '0);
        chk(acc_seen == 1'b0, "R6 same destination refused", 64'(acc_seen), 64'd0);
        issue(2'b01, 3, 1, 0, sa);
        chk(acc_seen == 1'b0, "R6 destination is other source refused", 64'(acc_seen), 64'd0);
        sb = 64'h8000_0000_0000_0001;
        issue(2'b01, 7, 1, 0, sb);
        chk(acc_seen == 1'b1, "R9 independent add accepted", 64'(acc_seen), 64'd1);
        chk(unit_busy == 2'b11, "R9 both units busy", 64'(unit_busy), 64'd3);
        wait_idle();
        readback(6, 20, gen(0, 20) * gen(3, 20), "R9 multiply result");
        readback(7, 20, gen(1, 20) + sb, "R9 add result");
        readback(3, 20, gen(3, 20), "R6 refused add left source intact");

        // R8: partial length with the destination as its own source.
        set_vl(10);
        issue(2'b01, 0, 0, 0, sb);
        wait_idle();
        readback(0, 9, gen(0, 9) + sb, "R8 last element inside VL");
        readback(0, 10, gen(0, 10), "R8 first element outside VL");
        readback(0, 63, gen(0, 63), "R8 top element untouched");

        // R7: zero vector length.
        set_vl(0);
        issue(2'b00, 3, 3, 3, '0);
        chk(unit_done == 2'b01, "R7 immediate done", 64'(unit_done), 64'd1);
        chk(unit_busy == 2'b00, "R7 unit stays idle", 64'(unit_busy), 64'd0);
        readback(3, 0, gen(3, 0), "R7 no element written");

        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule